// File: doc/BRIEF.md
# SPI Control Slave with Flow Control

This block is the serial control port of a larger chip. A host drives a chip select, a serial clock and a data-in line. The block answers on a data-out line whose pad driver is enabled only while a matched read is in progress. Every transaction opens with a header byte that holds a 7-bit device address and a direction bit. On a write, the bytes after the header are queued in a receive FIFO and handed to on-chip logic over a valid/ready handshake. On a read, the bytes that on-chip logic has queued in a transmit FIFO are shifted back to the host.

There are two sideband outputs. The active-low busy output tells the host to pause when the receive FIFO reaches a programmable high-water mark. It is released only when the FIFO falls below a separate low-water mark. The active-low interrupt output tells the host that response bytes are waiting. It is released during the read that takes the last queued byte, and it can be raised again only while the chip select is inactive.

All three serial inputs are synchronised into the system clock domain through two flops. Serial clock edges are found there, so the serial clock must run at no more than half the system clock rate.

Top module: `spi_ctl_slave`

## Requirements
- R1: After reset, irq_n and bsy_n are 1, miso_oe is 0, rx_valid is 0 and tx_ready is 1.
- R2: The first byte after cs_n falls is the header. Its bits 7..1 are the address, sent MSB first, and bit 0 is the direction (1 = read, 0 = write). The transaction is served only if bits 7..1 equal dev_addr.
- R3: In a matched write, every byte after the header is captured MSB first from mosi on the sclk rising edges. The bytes appear on rx_data in the order sent, and each one is removed by rx_valid and rx_ready high on the same clk edge.
- R4: In a matched read, miso changes only after sclk falls and is stable at each sclk rising edge. Each sclk falling edge that ends a byte (the one after the header, and the one after each data byte) takes the next byte from the transmit FIFO, which is then sent MSB first. If the FIFO is empty, 0x00 is sent.
- R5: miso_oe is 0 whenever cs_n is high, and stays 0 throughout a transaction whose address does not match. Such a transaction neither adds to the receive FIFO nor takes from the transmit FIFO.
- R6: irq_n goes low while cs_n is high and the transmit FIFO holds at least one byte. It returns to 1 after the sclk falling edge that takes the last queued byte, and not before.
- R7: irq_n never falls while cs_n is low. A byte queued during a transaction raises the interrupt only after cs_n rises.
- R8: bsy_n goes low when the receive FIFO count reaches high_water. It returns to 1 only when the count is below low_water.
- R9: While rx_valid is 1 and rx_ready is 0, rx_valid and rx_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr | input | 7 | Address this port answers to |
| high_water | input | RX_CW | Receive count at which busy is raised |
| low_water | input | RX_CW | Busy is released below this count |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe | output | 1 | Pad driver enable for miso_o (0 = high impedance) |
| bsy_n | output | 1 | Flow-control busy, active low |
| irq_n | output | 1 | Message-pending interrupt, active low |
| rx_data | output | 8 | Head byte of the receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ready | input | 1 | Consumer takes the head byte |
| tx_data | input | 8 | Byte to queue for the host |
| tx_valid | input | 1 | Producer offers tx_data |
| tx_ready | output | 1 | Transmit FIFO has room |

## Verification
The assertions assume that the host holds mosi steady around each sclk rising edge and keeps sclk low while cs_n changes. They also assume that each sclk level lasts several system clocks, so that no edge is lost in the synchroniser. The bench meets these conditions by moving every serial pin on a falling system-clock edge and holding each sclk phase for six system clocks. It samples miso just before each rising edge, and it queues or removes FIFO bytes only through the two handshakes.

// File: rtl/spi_ctl_pkg.sv
// Shared constants and types for the SPI control slave.
package spi_ctl_pkg;
    localparam int BYTE_W = 8;

    // Transaction phase of the serial engine.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-flop synchroniser for a group of asynchronous input pins.
// Assumes each pin is stable for longer than STAGES system clocks.
module spi_pin_sync #(
    parameter int N_PINS = 3,
    parameter int STAGES = 2,
    parameter logic [N_PINS-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] lvl_o
);
    logic [N_PINS-1:0] chain [STAGES];

    // Shift pin values through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign lvl_o = chain[STAGES-1];
endmodule

// File: rtl/spi_sync_fifo.sv
// Single-clock FIFO with occupancy count; push when full and pop when
// empty are dropped. Assumes DEPTH is a power of two.
module spi_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Store pushed data.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/spi_ctl_engine.sv
// Serial protocol engine: detects chip-select and serial-clock edges in
// the system domain, decodes the header byte, shifts write data into the
// receive path and read data out of the transmit path. Assumes inputs are
// already synchronised and sclk runs at most at half the clk rate.
module spi_ctl_engine
    import spi_ctl_pkg::*;
#(
    parameter int ADDR_W = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sclk_lvl,
    input  logic              mosi_lvl,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_wdata,
    output logic              tx_pop,
    input  logic [BYTE_W-1:0] tx_rdata,
    input  logic              tx_empty,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              cs_act
);
    localparam int BIT_W = $clog2(BYTE_W);

    phase_t            phase;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              byte_done;
    logic              cs_prev, sclk_prev;
    logic              cs_fall, cs_rise, sclk_rise, sclk_fall, last_bit;

    assign cs_fall   = cs_prev && !cs_lvl;
    assign cs_rise   = !cs_prev && cs_lvl;
    assign sclk_rise = !sclk_prev && sclk_lvl && !cs_lvl;
    assign sclk_fall = sclk_prev && !sclk_lvl && !cs_lvl;
    assign last_bit  = (bit_cnt == BIT_W'(BYTE_W - 1));
    assign cs_act    = !cs_lvl;

    assign rx_wdata = {rx_sh, mosi_lvl};
    assign rx_push  = sclk_rise && last_bit && (phase == PH_WRITE);
    assign tx_pop   = sclk_fall && byte_done && (phase == PH_READ) && !tx_empty;
    assign miso_o   = tx_sh[BYTE_W-1];
    assign miso_oe  = cs_act && (phase == PH_READ);

    // Remember previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_lvl;
            sclk_prev <= sclk_lvl;
        end
    end

    // Track phase, bit position and shift registers per transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else if (cs_rise) begin
            phase     <= PH_IDLE;
            byte_done <= 1'b0;
        end else if (cs_fall) begin
            phase     <= PH_HDR;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            if (sclk_rise) begin
                rx_sh     <= {rx_sh[BYTE_W-3:0], mosi_lvl};
                bit_cnt   <= bit_cnt + 1'b1;
                byte_done <= last_bit;
                if (last_bit && phase == PH_HDR) begin
                    if (rx_sh[ADDR_W-1:0] != dev_addr) phase <= PH_SKIP;
                    else if (mosi_lvl)                 phase <= PH_READ;
                    else                               phase <= PH_WRITE;
                end
            end
            if (sclk_fall) begin
                byte_done <= 1'b0;
                if (phase == PH_READ) begin
                    if (byte_done) tx_sh <= tx_empty ? '0 : tx_rdata;
                    else           tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_ctl_sideband.sv
// Busy and interrupt generation. Busy uses a high/low water hysteresis on
// the receive count; the interrupt follows the transmit queue and may only
// be raised while the chip select is inactive.
module spi_ctl_sideband #(
    parameter int RX_CW = 4,
    parameter int TX_CW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RX_CW-1:0] rx_count,
    input  logic [RX_CW-1:0] high_water,
    input  logic [RX_CW-1:0] low_water,
    input  logic [TX_CW-1:0] tx_count,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic             cs_act,
    output logic             bsy_n,
    output logic             irq_n
);
    logic busy_q, irq_q;

    // Busy with hysteresis between the two water marks.
    always_ff @(posedge clk) begin
        if (!rst_n)                                busy_q <= 1'b0;
        else if (!busy_q && rx_count >= high_water) busy_q <= 1'b1;
        else if (busy_q && rx_count < low_water)    busy_q <= 1'b0;
    end

    // Interrupt: clear on draining the last byte, set only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (tx_pop && !tx_push && tx_count == TX_CW'(1))
            irq_q <= 1'b0;
        else if (!cs_act && tx_count != '0)
            irq_q <= 1'b1;
    end

    assign bsy_n = !busy_q;
    assign irq_n = !irq_q;
endmodule

// File: rtl/spi_ctl_slave.sv
// SPI control slave with receive/transmit queues, busy flow control and
// message-pending interrupt. Assumes sclk at most half the clk rate and
// serial mode 0 (sample on rise, change on fall).
module spi_ctl_slave
    import spi_ctl_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = BYTE_W - 1,
    localparam int RX_CW  = $clog2(RX_DEPTH + 1),
    localparam int TX_CW  = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [RX_CW-1:0]  high_water,
    input  logic [RX_CW-1:0]  low_water,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              bsy_n,
    output logic              irq_n,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    logic [2:0]        pins_s;
    logic              cs_act, rx_push, tx_pop, tx_push;
    logic [BYTE_W-1:0] rx_wdata, tx_rdata;
    logic              rx_full, rx_empty, tx_full, tx_empty;
    logic [RX_CW-1:0]  rx_count;
    logic [TX_CW-1:0]  tx_count;

    spi_pin_sync #(.N_PINS(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i({cs_n, sclk, mosi}), .lvl_o(pins_s)
    );

    spi_ctl_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(pins_s[2]), .sclk_lvl(pins_s[1]), .mosi_lvl(pins_s[0]),
        .dev_addr(dev_addr),
        .rx_push(rx_push), .rx_wdata(rx_wdata),
        .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_empty(tx_empty),
        .miso_o(miso_o), .miso_oe(miso_oe), .cs_act(cs_act)
    );

    spi_sync_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_wdata),
        .pop(rx_ready), .rdata(rx_data),
        .full(rx_full), .empty(rx_empty), .count(rx_count)
    );

    assign tx_push  = tx_valid && !tx_full;
    assign tx_ready = !tx_full;
    assign rx_valid = !rx_empty;

    spi_sync_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_rdata),
        .full(tx_full), .empty(tx_empty), .count(tx_count)
    );

    spi_ctl_sideband #(.RX_CW(RX_CW), .TX_CW(TX_CW)) u_side (
        .clk(clk), .rst_n(rst_n),
        .rx_count(rx_count), .high_water(high_water), .low_water(low_water),
        .tx_count(tx_count), .tx_push(tx_push), .tx_pop(tx_pop),
        .cs_act(cs_act), .bsy_n(bsy_n), .irq_n(irq_n)
    );
endmodule

// File: rtl/spi_ctl_slave_chk.sv
// Protocol checker for spi_ctl_slave, attached by bind.
module spi_ctl_slave_chk #(
    parameter int RX_CW = 4,
    parameter int TX_CW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             cs_act,
    input logic             miso_oe,
    input logic             irq_n,
    input logic             bsy_n,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [7:0]       rx_data,
    input logic [RX_CW-1:0] rx_count,
    input logic [RX_CW-1:0] high_water,
    input logic [RX_CW-1:0] low_water,
    input logic [TX_CW-1:0] tx_count
);
    logic [1:0] cs_hi_cnt;

    // Count consecutive clocks with the chip-select pin high.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_n)     cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 3) cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    // R5
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt == 2'd3) |-> !miso_oe);

    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(!cs_act));

    // R6
    irq_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> ($past(tx_count) == TX_CW'(1) && tx_count == '0));

    // R8
    bsy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bsy_n) |-> ($past(rx_count) >= $past(high_water)));

    // R8
    bsy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_n) |-> ($past(rx_count) < $past(low_water)));

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_ctl_slave spi_ctl_slave_chk #(.RX_CW(RX_CW), .TX_CW(TX_CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_act(cs_act),
    .miso_oe(miso_oe), .irq_n(irq_n), .bsy_n(bsy_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_count(rx_count), .high_water(high_water), .low_water(low_water),
    .tx_count(tx_count)
);

// File: tb/spi_ctl_slave_tb.sv
`timescale 1ns/1ps
module spi_ctl_slave_tb;
    localparam int HALF = 6;
    localparam logic [6:0] MY_ADDR = 7'h2A;
    // {header, d0, d1, accept}
    localparam logic [31:0] VEC [6] = '{
        32'h54_3C_A5_01,   // matched write
        32'h56_11_22_00,   // mismatched write
        32'h55_96_0F_01,   // matched read
        32'h57_C3_5A_00,   // mismatched read
        32'h54_FF_00_01,   // matched write
        32'h55_80_01_01    // matched read
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic rx_ready = 1'b0, tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic [3:0] high_water = 4'd4, low_water = 4'd2;
    logic miso_o, miso_oe, bsy_n, irq_n, rx_valid, tx_ready;
    logic [7:0] rx_data;
    int n_chk = 0, n_fail = 0;
    bit oe_seen;

    always #2.5 clk = ~clk;

    spi_ctl_slave u_dut (
        .clk(clk), .rst_n(rst_n), .dev_addr(MY_ADDR),
        .high_water(high_water), .low_water(low_water),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso_o(miso_o), .miso_oe(miso_oe), .bsy_n(bsy_n), .irq_n(irq_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_begin();
        oe_seen = 1'b0;
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso_o;
            if (miso_oe) oe_seen = 1'b1;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_end();
        tick(HALF);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_data = d;
        tx_valid = 1'b1;
        tick(1);
        tx_valid = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] d, output logic v);
        d = rx_data;
        v = rx_valid;
        rx_ready = 1'b1;
        tick(1);
        rx_ready = 1'b0;
    endtask

    initial begin
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r0, r1, d;
        logic v;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 irq_n", irq_n, 1);
        chk("R1 bsy_n", bsy_n, 1);
        chk("R1 miso_oe", miso_oe, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 tx_ready", tx_ready, 1);

        // Table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < 6; k++) begin
            logic [7:0] hdr, d0, d1;
            logic acc;
            hdr = VEC[k][31:24]; d0 = VEC[k][23:16]; d1 = VEC[k][15:8]; acc = VEC[k][0];
            if (hdr[0]) begin
                push_tx(d0);
                push_tx(d1);
                tick(4);
                chk("R6 irq pending", irq_n, 0);
            end
            spi_begin();
            spi_byte(hdr, r0);
            spi_byte(hdr[0] ? 8'h00 : d0, r0);
            spi_byte(hdr[0] ? 8'h00 : d1, r1);
            spi_end();
            if (!hdr[0] && acc) begin
                pop_rx(d, v); chk("R3 first byte", {v, d}, {1'b1, d0});
                pop_rx(d, v); chk("R3 second byte", {v, d}, {1'b1, d1});
                chk("R3 drained", rx_valid, 0);
                chk("R2 write no oe", oe_seen, 0);
            end else if (!hdr[0]) begin
                chk("R5 mismatch write ignored", rx_valid, 0);
                chk("R5 mismatch write oe", oe_seen, 0);
            end else if (acc) begin
                chk("R4 read byte 0", r0, d0);
                chk("R4 read byte 1", r1, d1);
                chk("R2 read oe", oe_seen, 1);
                chk("R6 irq released", irq_n, 1);
            end else begin
                chk("R5 mismatch read oe", oe_seen, 0);
                chk("R5 mismatch read queue kept", irq_n, 0);
                spi_begin();
                spi_byte(8'h55, r0);
                spi_byte(8'h00, r0);
                spi_end();
                chk("R5 queued byte intact", r0, d0);
            end
        end

        // R4 empty queue sends 0x00
        spi_begin();
        spi_byte(8'h55, r0);
        spi_byte(8'h00, r0);
        spi_end();
        chk("R4 empty read", r0, 8'h00);

        // R6 partial read keeps interrupt, prefetch takes next byte
        push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
        tick(4);
        spi_begin(); spi_byte(8'h55, r0); spi_byte(8'h00, r0); spi_end();
        chk("R6 partial read data", r0, 8'h11);
        chk("R6 irq held after partial read", irq_n, 0);
        spi_begin(); spi_byte(8'h55, r0); spi_byte(8'h00, r0); spi_end();
        chk("R6 last byte data", r0, 8'h33);
        chk("R6 irq released on drain", irq_n, 1);

        // R7 byte queued mid-transaction raises irq only after cs_n rises
        cs_n = 1'b0;
        tick(HALF);
        push_tx(8'h5A);
        tick(6);
        chk("R7 no irq while selected", irq_n, 1);
        cs_n = 1'b1;
        tick(6);
        chk("R7 irq after deselect", irq_n, 0);
        spi_begin(); spi_byte(8'h55, r0); spi_byte(8'h00, r0); spi_end();
        chk("R7 drained byte", r0, 8'h5A);

        // R8 busy hysteresis, R9 hold
        spi_begin();
        spi_byte(8'h54, r0);
        for (int b = 1; b <= 5; b++) begin
            spi_byte(8'h40 + 8'(b), r0);
            tick(2);
            if (b == 3) chk("R8 not busy at 3", bsy_n, 1);
            if (b == 4) chk("R8 busy at high mark", bsy_n, 0);
        end
        spi_end();
        chk("R9 head held", {rx_valid, rx_data}, {1'b1, 8'h41});
        for (int b = 1; b <= 3; b++) begin
            pop_rx(d, v);
            chk("R3 busy burst data", d, 8'h40 + 8'(b));
        end
        tick(2);
        chk("R8 still busy at low mark", bsy_n, 0);
        pop_rx(d, v);
        tick(2);
        chk("R8 released below low mark", bsy_n, 1);
        pop_rx(d, v);
        chk("R3 final burst byte", d, 8'h45);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule